// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a free-running 24-bit down-counter that gives system software a regular heartbeat. Software programs a reload value, picks whether the count advances on every core clock or only on an external single-cycle reference strobe, and enables the counter. The counter then walks down from the reload value to zero. On the tick that finds it at zero it wraps back to the reload value, raises a sticky wrap flag and, if tick interrupts are enabled, emits a one-cycle request pulse toward the interrupt controller.

The block is reached through a simple 32-bit register port with four word-aligned registers: control/status at 0x0, reload at 0x4, current count at 0x8 and a read-only calibration constant at 0xC. Reading the control register clears the wrap flag. Any write to the current-count register restarts the period. A reload value of zero turns the counter into a one-shot that disables itself on its first wrap.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads as zero except the calibration word, and the interrupt request output is low.
- R2: The control register holds enable at bit 0, tick-interrupt enable at bit 1, source select at bit 2 and the wrap flag at bit 16; a write changes only bits 2:0, and all other bits read as zero.
- R3: A read of the control register returns the wrap flag and clears it in the same access, unless a wrap happens in that same cycle, in which case the flag stays set.
- R4: Enabling the counter loads it from the reload register; each period then lasts reload+1 count ticks, and on the tick that finds the count at zero the counter reloads and the wrap flag is set.
- R5: When tick interrupts are enabled, each wrap produces exactly one single-cycle pulse on `irq_req` in the cycle after the wrap; with tick interrupts disabled no pulse appears, though the flag is still set.
- R6: When the reload register holds zero at a wrap, the enable bit clears and counting stops.
- R7: A write of any data to the current-count register (offset 0x8) reloads the counter from the reload register and clears the wrap flag.
- R8: While the counter is disabled, the current-count register reads as zero.
- R9: The calibration register (offset 0xC) always reads 10000, and the reload register (offset 0x4) keeps 24 bits with bits 31:24 reading zero.
- R10: With source select 1 the count advances on every clock; with source select 0 it advances only in cycles where `ref_strobe` is high.
- R11: Changing the source-select bit while the counter stays enabled reloads the counter, and no count tick is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe for this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| ref_strobe | input | 1 | Single-cycle reference tick, synchronous to clk |
| irq_req | output | 1 | One-cycle interrupt request pulse per wrap |

## Verification
The count is exercised from a table of reload values (zero-adjacent, small, mid-range and full 24-bit) sampled at points just before, at and after a wrap, which separates an off-by-one period from a correct reload+1 period and shows whether the flag is set on the right tick. The interrupt path is run with the tick-interrupt bit on and off over several periods, so a stuck or stretched request is told apart from a correctly counted pulse. Strobe-driven counting is contrasted with idle cycles and then with a live switch to core-clock counting, which distinguishes decrementing on the strobe from decrementing every cycle and shows the forced reload. Directed accesses cover the one-shot stop, the restart by a data-independent write, the write mask on the control register and the clear-on-read flag.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int unsigned BUS_W = 32;

    // register select, taken from byte-address bits 3:2
    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_CUR    = 2'd2;
    localparam logic [1:0] SEL_CAL    = 2'd3;

    // control word bit positions
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_INT  = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    typedef struct packed {
        logic en;
        logic int_en;
        logic src_core;
        logic flag;
    } ctrl_t;

endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel (
    input  logic en,
    input  logic src_core,
    input  logic ref_strobe,
    output logic tick
);

    always_comb begin
        tick = 1'b0;
        if (en) begin
            tick = src_core ? 1'b1 : ref_strobe;
        end
    end

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                expire   = 1'b1;
                st_d.cnt = load_val;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur = st_q.cnt;

endmodule

// File: rtl/tick_regs.sv
module tick_regs #(
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CAL_VALUE = 10000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [tick_pkg::BUS_W-1:0] bus_wdata,
    output logic [tick_pkg::BUS_W-1:0] bus_rdata,
    input  logic                       expire,
    input  logic [CNT_W-1:0]           cur,
    output logic                       en,
    output logic                       src_core,
    output logic                       flag,
    output logic [CNT_W-1:0]           reload,
    output logic                       load,
    output logic                       irq
);

    import tick_pkg::*;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
        logic             irq;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic [1:0] sel;
    logic       rd_ctrl, wr_ctrl, wr_reload, wr_cur, rd_any;
    logic       src_change, en_rise;

    assign sel       = bus_addr[3:2];
    assign rd_any    = bus_valid && !bus_write;
    assign rd_ctrl   = rd_any && (sel == SEL_CTRL);
    assign wr_ctrl   = bus_valid && bus_write && (sel == SEL_CTRL);
    assign wr_reload = bus_valid && bus_write && (sel == SEL_RELOAD);
    assign wr_cur    = bus_valid && bus_write && (sel == SEL_CUR);

    assign en_rise    = wr_ctrl && bus_wdata[BIT_EN] && !st_q.ctrl.en;
    assign src_change = wr_ctrl && bus_wdata[BIT_EN] && st_q.ctrl.en
                        && (bus_wdata[BIT_SRC] != st_q.ctrl.src_core);

    // restart requests go to the counter; they take priority over a tick
    assign load = wr_cur || en_rise || src_change;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (wr_ctrl) begin
            st_d.ctrl.en       = bus_wdata[BIT_EN];
            st_d.ctrl.int_en   = bus_wdata[BIT_INT];
            st_d.ctrl.src_core = bus_wdata[BIT_SRC];
        end
        if (wr_reload) begin
            st_d.reload = bus_wdata[CNT_W-1:0];
        end

        // clear by read or restart, then a wrap in the same cycle wins
        if (rd_ctrl || wr_cur) begin
            st_d.ctrl.flag = 1'b0;
        end
        if (expire) begin
            st_d.ctrl.flag = 1'b1;
            st_d.irq       = st_q.ctrl.int_en;
            if (st_q.reload == '0) begin
                st_d.ctrl.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    logic [BUS_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_EN]   = st_q.ctrl.en;
        ctrl_word[BIT_INT]  = st_q.ctrl.int_en;
        ctrl_word[BIT_SRC]  = st_q.ctrl.src_core;
        ctrl_word[BIT_FLAG] = st_q.ctrl.flag;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            unique case (sel)
                SEL_CTRL:   bus_rdata = ctrl_word;
                SEL_RELOAD: bus_rdata = BUS_W'(st_q.reload);
                SEL_CUR:    bus_rdata = st_q.ctrl.en ? BUS_W'(cur) : '0;
                default:    bus_rdata = BUS_W'(CAL_VALUE);
            endcase
        end
    end

    assign en       = st_q.ctrl.en;
    assign src_core = st_q.ctrl.src_core;
    assign flag     = st_q.ctrl.flag;
    assign reload   = st_q.reload;
    assign irq      = st_q.irq;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:CNT_W]};

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ref_strobe,
    output logic              irq_req
);

    logic             ctrl_en, ctrl_src, ctrl_flag;
    logic [CNT_W-1:0] reload_val, cnt_cur;
    logic             cnt_load, cnt_tick, cnt_expire;

    tick_regs #(
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .CAL_VALUE (CAL_VALUE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .expire    (cnt_expire),
        .cur       (cnt_cur),
        .en        (ctrl_en),
        .src_core  (ctrl_src),
        .flag      (ctrl_flag),
        .reload    (reload_val),
        .load      (cnt_load),
        .irq       (irq_req)
    );

    tick_src_sel u_src (
        .en         (ctrl_en),
        .src_core   (ctrl_src),
        .ref_strobe (ref_strobe),
        .tick       (cnt_tick)
    );

    tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_tick),
        .load     (cnt_load),
        .load_val (reload_val),
        .cur      (cnt_cur),
        .expire   (cnt_expire)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CAL_VALUE = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq_req,
    input logic              en,
    input logic              flag,
    input logic              expire,
    input logic [CNT_W-1:0]  reload
);

    logic rd;
    assign rd = bus_valid && !bus_write;

    p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[3:2] == 2'd0) |-> ((bus_rdata & ~32'h0001_0007) == 32'd0));

    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[3:2] == 2'd0 && !expire) |=> !flag);

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> flag);

    p_zero_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload == '0) |=> !en);

    p_cur_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[3:2] == 2'd2 && !en) |-> (bus_rdata == 32'd0));

    p_cal_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[3:2] == 2'd3) |-> (bus_rdata == 32'(CAL_VALUE)));

    p_reload_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr[3:2] == 2'd1) |-> (bus_rdata[31:CNT_W] == '0));

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .CAL_VALUE (CAL_VALUE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .en        (ctrl_en),
    .flag      (ctrl_flag),
    .expire    (cnt_expire),
    .reload    (reload_val)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_strobe = 1'b0;
    logic        irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ref_strobe (ref_strobe),
        .irq_req    (irq_req)
    );

    localparam logic [3:0] A_CTRL = 4'h0, A_REL = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

    // reload, edges after enable, expected count then, expected flag one edge later
    typedef struct packed {
        logic [23:0] rel;
        logic [31:0] k;
        logic [23:0] exp_cur;
        logic        exp_flag;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{24'd5,        32'd3,  24'd2,        1'b0},
        '{24'd5,        32'd6,  24'd5,        1'b1},
        '{24'd5,        32'd8,  24'd3,        1'b1},
        '{24'd16,       32'd15, 24'd1,        1'b0},
        '{24'd16,       32'd17, 24'd16,       1'b1},
        '{24'd1,        32'd5,  24'd0,        1'b1},
        '{24'hFF_FFFF,  32'd2,  24'hFF_FFFD,  1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_and_clear();
        logic [31:0] d;
        bus_wr(A_CTRL, 32'h0);
        bus_rd(A_CTRL, d);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int pulses;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq low", {31'd0, irq_req}, 32'd0);
        bus_rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
        bus_rd(A_REL, d);  check("R1 reload", d, 32'h0);
        bus_rd(A_CUR, d);  check("R1 current", d, 32'h0);
        bus_rd(A_CAL, d);  check("R9 calibration", d, 32'd10000);

        // R4 period table, core clock source (R10)
        foreach (VECS[i]) begin
            stop_and_clear();
            bus_wr(A_REL, {8'h0, VECS[i].rel});
            bus_wr(A_CTRL, 32'h5);
            idle(int'(VECS[i].k));
            bus_rd(A_CUR, d);
            check("R4 count", d, {8'h0, VECS[i].exp_cur});
            bus_rd(A_CTRL, d);
            check("R4 flag", d, 32'h5 | (32'(VECS[i].exp_flag) << 16));
        end

        // R5 interrupt pulses, three wraps in nine edges with reload 2
        stop_and_clear();
        bus_wr(A_REL, 32'd2);
        bus_wr(A_CTRL, 32'h7);
        pulses = 0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (irq_req) pulses++;
        end
        check("R5 pulses with int on", 32'(pulses), 32'd3);
        stop_and_clear();
        bus_wr(A_CTRL, 32'h5);
        pulses = 0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (irq_req) pulses++;
        end
        check("R5 no pulse with int off", 32'(pulses), 32'd0);
        bus_rd(A_CTRL, d);
        check("R5 flag still set", d, 32'h0001_0005);

        // R6 zero reload stops after one wrap; R8 disabled reads zero
        stop_and_clear();
        bus_wr(A_REL, 32'd0);
        bus_wr(A_CTRL, 32'h5);
        idle(1);
        bus_rd(A_CTRL, d);
        check("R6 enable cleared", d, 32'h0001_0004);
        bus_rd(A_CUR, d);
        check("R8 disabled current", d, 32'h0);

        // R7 write to current restarts and clears flag
        stop_and_clear();
        bus_wr(A_REL, 32'd10);
        bus_wr(A_CTRL, 32'h5);
        idle(12);
        bus_wr(A_CUR, 32'h0000_1234);
        bus_rd(A_CUR, d);
        check("R7 restart value", d, 32'd10);
        bus_rd(A_CTRL, d);
        check("R7 flag cleared", d, 32'h5);

        // R10 strobe source
        stop_and_clear();
        bus_wr(A_REL, 32'd3);
        bus_wr(A_CTRL, 32'h1);
        idle(5);
        bus_rd(A_CUR, d);
        check("R10 no strobe holds", d, 32'd3);
        for (int i = 0; i < 2; i++) begin
            ref_strobe = 1'b1;
            @(negedge clk);
            ref_strobe = 1'b0;
        end
        bus_rd(A_CUR, d);
        check("R10 two strobes", d, 32'd1);

        // R11 source change while enabled reloads
        bus_wr(A_CTRL, 32'h5);
        bus_rd(A_CUR, d);
        check("R11 reload on source change", d, 32'd3);
        bus_rd(A_CUR, d);
        check("R10 every-clock count", d, 32'd2);

        // R2 write mask, R3 clear on read
        idle(6);
        bus_wr(A_CTRL, 32'hFFFF_FFF8);
        bus_rd(A_CTRL, d);
        check("R2 only low bits written", d, 32'h0001_0000);
        bus_rd(A_CTRL, d);
        check("R3 flag cleared by read", d, 32'h0);

        // R9 reload width
        bus_wr(A_REL, 32'hABCD_EF12);
        bus_rd(A_REL, d);
        check("R9 reload upper zero", d, 32'h00CD_EF12);
        bus_rd(A_CAL, d);
        check("R9 calibration again", d, 32'd10000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule